// File: doc/BRIEF.md
# Small Multi-Function Arithmetic-Logic Unit

This block is a purely combinational unit. It takes two 4-bit operands and a 3-bit function code, and it returns an 8-bit result. Each function has its own datapath. A selector driven by the function code decides which datapath drives the result.

The unit offers six operations:

- two independent additions that must always agree;
- sign extension of the second operand;
- two whole-operand flags, one for "any bit set" and one for "every bit set";
- packing of both operands into one byte.

One of the adders is a structural ripple-carry chain built from full-adder cells. It sits outside the selection logic and feeds the selector as an ordinary wire.

The unit has no clock, no state and no handshake. The result follows the operands and the function code after propagation delay. It suits a datapath stage that registers the result elsewhere.

Top module: `mini_alu`

## Requirements
- R1: Code 3'd0 gives the sum of the operands from a chain of four full-adder cells. The carry-in is 0, the final carry is at result bit 4, and result bits 7:5 are 0.
- R2: Code 3'd1 gives the sum from the built-in addition operator, zero-extended. The 5-bit sum is in bits 4:0 and bits 7:5 are 0.
- R3: Codes 3'd0 and 3'd1 give identical results for all 256 operand pairs. For operands 4'hF and 4'hF both give 8'h1E.
- R4: Code 3'd2 gives the second operand sign-extended. Its bit 3 is copied into result bits 7:4, and bits 3:0 equal the operand.
- R5: Code 3'd3 gives 8'h01 when any of the eight operand bits is 1, and 8'h00 otherwise.
- R6: Code 3'd4 gives 8'h01 only when all eight operand bits are 1, and 8'h00 otherwise.
- R7: Code 3'd5 places the first operand in bits 7:4 and the second operand in bits 3:0.
- R8: Codes 3'd6 and 3'd7 give 8'h00 for any operands.
- R9: Each full-adder cell gives sum = a^b^ci and carry = majority(a,b,ci). Carries ripple from bit 0 to bit 3, so 4'h1 plus 4'hF gives 8'h10 under code 3'd0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| fn_sel | input | 3 | Function code |
| result | output | 8 | Selected result, with unused high bits zero |

## Verification
The block holds no state, so a wrong internal signal shows at the ports in the same evaluation as the stimulus. Examples are a broken carry link, a miswired cell or a stale selector branch. The bench visits every operand pair under every function code. A carry fault therefore surfaces as soon as a pair needs that carry, and code 3'd0 then disagrees with code 3'd1. Flag and extension faults show up on the pairs where the top bit or the all-ones pattern matters.

// File: rtl/mini_alu_pkg.sv
package mini_alu_pkg;
  typedef enum logic [2:0] {
    FN_ADD_CHAIN = 3'd0,
    FN_ADD_OP    = 3'd1,
    FN_SEXT_B    = 3'd2,
    FN_ANY_SET   = 3'd3,
    FN_ALL_SET   = 3'd4,
    FN_PACK      = 3'd5
  } alu_fn_e;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);

  // R9: the two output bits together count the ones on the inputs
  always_comb begin
    p_cell_count_r9: assert ({co, s} == 2'(a) + 2'(b) + 2'(ci))
      else $error("p_cell_count_r9: cell output mismatch");
  end
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_stage
    fa_cell u_cell (
      .a (x[i]),
      .b (y[i]),
      .ci(carry[i]),
      .s (sum[i]),
      .co(carry[i+1])
    );
  end

  assign cout = carry[W];

  // R1: the chain total matches the arithmetic sum of its inputs
  always_comb begin
    p_chain_total_r1: assert ({cout, sum} == (W+1)'(x) + (W+1)'(y) + (W+1)'(cin))
      else $error("p_chain_total_r1: chain sum mismatch");
  end
endmodule

// File: rtl/mini_alu.sv
module mini_alu
  import mini_alu_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  input  logic [2:0]       fn_sel,
  output logic [2*OPW-1:0] result
);
  localparam int RW  = 2 * OPW;
  localparam int PAD = RW - OPW - 1;

  logic [OPW-1:0] chain_sum;
  logic           chain_co;
  logic [OPW:0]   op_sum;
  logic           any_flag;
  logic           all_flag;

  // Structural adder, kept outside the selector
  ripple_adder #(.W(OPW)) u_chain (
    .x   (op_a),
    .y   (op_b),
    .cin (1'b0),
    .sum (chain_sum),
    .cout(chain_co)
  );

  assign op_sum   = {1'b0, op_a} + {1'b0, op_b};
  assign any_flag = |{op_a, op_b};
  assign all_flag = &{op_a, op_b};

  always_comb begin
    case (alu_fn_e'(fn_sel))
      FN_ADD_CHAIN: result = {{PAD{1'b0}}, chain_co, chain_sum};
      FN_ADD_OP:    result = {{PAD{1'b0}}, op_sum};
      FN_SEXT_B:    result = {{OPW{op_b[OPW-1]}}, op_b};
      FN_ANY_SET:   result = {{(RW-1){1'b0}}, any_flag};
      FN_ALL_SET:   result = {{(RW-1){1'b0}}, all_flag};
      FN_PACK:      result = {op_a, op_b};
      default:      result = '0;
    endcase
  end

  always_comb begin
    // R3: the structural and operator adders agree
    p_adders_agree_r3: assert ({chain_co, chain_sum} == op_sum)
      else $error("p_adders_agree_r3: adder disagreement");
    // R6: an all-ones operand set always implies some bit set
    p_flag_order_r6: assert (!all_flag || any_flag)
      else $error("p_flag_order_r6: flag ordering violated");
    // R2: the additions leave the pad bits clear
    p_pad_clear_r2: assert (!(fn_sel == 3'd0 || fn_sel == 3'd1) || result[RW-1:OPW+1] == '0)
      else $error("p_pad_clear_r2: high bits set on add");
    // R8: unused codes drive zero
    p_unused_zero_r8: assert (fn_sel < 3'd6 || result == '0)
      else $error("p_unused_zero_r8: nonzero on unused code");
  end
endmodule

// File: tb/sim_mini_alu.sv
module sim_mini_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic [2:0] fn_sel = '0;
  logic [7:0] result;

  typedef struct {
    logic [7:0] exp;
    string      tag;
    logic [3:0] a;
    logic [3:0] b;
    logic [2:0] fn;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  mini_alu u0 (.op_a(op_a), .op_b(op_b), .fn_sel(fn_sel), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b, input logic [2:0] f);
    case (f)
      3'd0, 3'd1: return 8'(a) + 8'(b);
      3'd2:       return {{4{b[3]}}, b};
      3'd3:       return {7'd0, |{a, b}};
      3'd4:       return {7'd0, &{a, b}};
      3'd5:       return {a, b};
      default:    return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Driver: applies inputs on the falling edge and queues the expected result
  task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [2:0] f,
                       input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; fn_sel = f;
    it.exp = exp; it.tag = tag; it.a = a; it.b = b; it.fn = f;
    sb.push_back(it);
  endtask

  // Monitor: compares just after the rising edge, away from input changes
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (result !== it.exp) begin
        n_bad++;
        $display("FAIL %s: fn=%0d a=%h b=%h actual=%h expected=%h",
                 it.tag, it.fn, it.a, it.b, result, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // Quiet state: all-zero operands under each code
    drive(4'h0, 4'h0, 3'd0, 8'h00, "R1");
    drive(4'h0, 4'h0, 3'd3, 8'h00, "R5");
    // R3: both adders on the all-ones corner
    drive(4'hF, 4'hF, 3'd0, 8'h1E, "R3");
    drive(4'hF, 4'hF, 3'd1, 8'h1E, "R3");
    // R9: a carry that passes every stage
    drive(4'h1, 4'hF, 3'd0, 8'h10, "R9");
    drive(4'h8, 4'h8, 3'd0, 8'h10, "R9");
    // R4: negative and positive extension
    drive(4'h0, 4'h9, 3'd2, 8'hF9, "R4");
    drive(4'hF, 4'h7, 3'd2, 8'h07, "R4");
    // R5 and R6 at their single-bit boundaries
    drive(4'h0, 4'h1, 3'd3, 8'h01, "R5");
    drive(4'hF, 4'hE, 3'd4, 8'h00, "R6");
    drive(4'hF, 4'hF, 3'd4, 8'h01, "R6");
    // R7 and R8
    drive(4'hA, 4'h5, 3'd5, 8'hA5, "R7");
    drive(4'hF, 4'hF, 3'd6, 8'h00, "R8");
    drive(4'hF, 4'hF, 3'd7, 8'h00, "R8");
    // Every operand pair under every code; R3 agreement is checked on codes 0 and 1
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int f = 0; f < 8; f++)
          drive(4'(a), 4'(b), 3'(f), model(4'(a), 4'(b), 3'(f)),
                (f < 2) ? "R3" : tag_of(3'(f)));
    wait (sb.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule